// File: doc/BRIEF.md
# Block-Bounded Serial Pattern Detector

This block watches a serial bit stream that delivers one bit per clock. It raises a flag on the bit that completes the sequence 1, 1, 0, 1, with the earliest bit first. The stream is cut into consecutive blocks of 256 bits. A sequence that begins in one block and ends in the next is never reported.

Two small machines work together. A free-running position counter marks where each bit falls inside its block. A four-state recognizer tracks how much of the sequence has been seen so far. The recognizer is built as a tiny counter whose clear input outranks its increment and load inputs. When the position counter wraps from its last position back to zero, it drives that clear. The bit sampled on the wrap edge is still tested for a completed match, and the following block starts with nothing matched.

The flag is a Mealy output. It depends on the recognizer state and on the bit currently at the input, so it is high in the same cycle as the completing bit.

Top module: `blkpat_detect`

## Requirements
- R1: `match_flag` is 1 during the cycle in which `serial_in` carries the last bit of 1,1,0,1 (earliest bit first), when all four bits fall in the same block. In every other cycle it is 0.
- R2: After a zero ends a partial match, the search begins again from the next 1. For example, 1,0,0,1,1,0,1 flags only on its final bit.
- R3: Matches may overlap. The final 1 of one match can be the first bit of the next match, so 1,1,0,1,1,0,1 flags on bits 4 and 7.
- R4: A run of three or more ones followed by 0,1 is detected. For example, 1,1,1,0,1 flags on its final bit.
- R5: A block is 256 consecutive bits. The first bit sampled after reset is position 0, and positions count upward by one per clock, wrapping from 255 to 0.
- R6: A match whose last bit lands on position 255 is flagged.
- R7: A partial match is dropped at the end of a block. If 1,1,0 occupies positions 253 to 255, a 1 at position 0 of the next block is not flagged. No flag can appear at positions 0, 1 or 2.
- R8: Each block starts with nothing matched, so 1,1,0,1 at positions 0 to 3 flags at position 3.
- R9: Synchronous active-high reset `rst` clears both the position counter and the recognizer. A partial match in progress at reset does not complete afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| serial_in | input | 1 | Serial data, one bit per clock |
| match_flag | output | 1 | Mealy flag, high on the bit that completes a match |

## Verification
On every cycle, the assertions check several structural properties. The position counter must step by one and wrap at the block end. The recognizer must be idle after a block-end clear or a reset. The third-bit-matched state may be entered only from the second. A flag must be followed by the one-bit-matched state. No flag may appear in the first three positions of a block. Other behaviours depend on whole bit sequences and on exact block positions, and only the bench scenarios can show them. These include the overlapping and restart patterns, a match ending exactly on position 255, a partial match dropped across the wrap, and a block that is re-aligned after a reset in the middle of the stream.

// File: rtl/blkpat_pkg.sv
package blkpat_pkg;

    // Recognizer progress, encoded as a count of matched leading bits
    localparam int unsigned REC_W = 2;
    localparam logic [REC_W-1:0] ST_IDLE  = 2'd0;
    localparam logic [REC_W-1:0] ST_ONE   = 2'd1;
    localparam logic [REC_W-1:0] ST_TWO   = 2'd2;
    localparam logic [REC_W-1:0] ST_THREE = 2'd3;

    // Control word for the recognizer's state counter
    typedef struct packed {
        logic clr;
        logic ld_one;
        logic inc;
    } rec_ctl_t;

endpackage

// File: rtl/blkpat_block_ctr.sv
module blkpat_block_ctr #(
    parameter int unsigned POS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    output logic [POS_W-1:0] pos_o,
    output logic             blk_end_o
);
    localparam logic [POS_W-1:0] POS_LAST = {POS_W{1'b1}};

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } ctr_regs_t;

    ctr_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d.pos = '0;
        end else begin
            regs_d.pos = regs_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign pos_o     = regs_q.pos;
    assign blk_end_o = (regs_q.pos == POS_LAST);

    // R5
    ctr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (regs_q.pos == POS_LAST) |=> (regs_q.pos == '0));

    // R5
    ctr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (regs_q.pos != POS_LAST) |=> (regs_q.pos == POS_W'($past(regs_q.pos) + 1'b1)));

endmodule

// File: rtl/blkpat_recog.sv
module blkpat_recog
    import blkpat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             bit_i,
    output logic             hit_o,
    output logic [REC_W-1:0] state_o
);
    typedef struct packed {
        logic [REC_W-1:0] st;
    } rec_regs_t;

    rec_regs_t regs_d, regs_q;
    rec_ctl_t  ctl;

    // Decode counter controls from present progress and incoming bit
    always_comb begin
        ctl = '0;
        unique case (regs_q.st)
            ST_IDLE:  begin
                ctl.inc = bit_i;
                ctl.clr = !bit_i;
            end
            ST_ONE:   begin
                ctl.inc = bit_i;
                ctl.clr = !bit_i;
            end
            ST_TWO:   begin
                ctl.inc = !bit_i;
            end
            default:  begin
                ctl.ld_one = bit_i;
                ctl.clr    = !bit_i;
            end
        endcase
    end

    // State counter: reset and block clear outrank all other controls
    always_comb begin
        regs_d = regs_q;
        if (rst || clr_i) begin
            regs_d.st = ST_IDLE;
        end else if (ctl.clr) begin
            regs_d.st = ST_IDLE;
        end else if (ctl.ld_one) begin
            regs_d.st = ST_ONE;
        end else if (ctl.inc) begin
            regs_d.st = regs_q.st + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign hit_o   = (regs_q.st == ST_THREE) && bit_i;
    assign state_o = regs_q.st;

    // R7
    blk_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (regs_q.st == ST_IDLE));

    // R3
    overlap_resume_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_o && !clr_i) |=> (regs_q.st == ST_ONE));

    // R1
    three_from_two_chk: assert property (@(posedge clk) disable iff (rst)
        (regs_q.st == ST_THREE) |-> ($past(regs_q.st) == ST_TWO));

endmodule

// File: rtl/blkpat_detect.sv
module blkpat_detect
    import blkpat_pkg::*;
#(
    parameter int unsigned POS_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic serial_in,
    output logic match_flag
);
    logic [POS_W-1:0] blk_pos;
    logic             blk_end;
    logic             hit;
    logic [REC_W-1:0] rec_state;

    blkpat_block_ctr #(
        .POS_W (POS_W)
    ) i_block_ctr (
        .clk       (clk),
        .rst       (rst),
        .pos_o     (blk_pos),
        .blk_end_o (blk_end)
    );

    blkpat_recog i_recog (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (blk_end),
        .bit_i   (serial_in),
        .hit_o   (hit),
        .state_o (rec_state)
    );

    assign match_flag = hit;

    // R7
    no_early_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (blk_pos < POS_W'(3)) |-> !match_flag);

    // R9
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> ((blk_pos == '0) && (rec_state == ST_IDLE)));

endmodule

// File: tb/test_blkpat_detect.sv
`timescale 1ns/1ps
module test_blkpat_detect;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic serial_in = 1'b0;
    logic match_flag;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // reference model state
    int         ref_pos = 0;
    int         ref_cnt = 0;
    logic [3:0] ref_hist = 4'b0;

    always #2 clk = ~clk;

    blkpat_detect i_blkpat_detect (
        .clk        (clk),
        .rst        (rst),
        .serial_in  (serial_in),
        .match_flag (match_flag)
    );

    // {bit, expected flag}, starting at block position 0
    localparam logic [1:0] VEC [24] = '{
        2'b10, 2'b10, 2'b00, 2'b11,
        2'b10, 2'b00, 2'b11,
        2'b00, 2'b00,
        2'b10, 2'b10, 2'b10, 2'b00, 2'b11,
        2'b10, 2'b00, 2'b00, 2'b10, 2'b10, 2'b00, 2'b11,
        2'b00, 2'b00, 2'b00
    };

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s pos=%0d match_flag=%0b expected=%0b", tag, ref_pos, act, exp);
        end
    endtask

    task automatic model_reset();
        ref_pos  = 0;
        ref_cnt  = 0;
        ref_hist = 4'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        serial_in = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1 rst = 1'b0;
        model_reset();
    endtask

    // Drive one bit, compare against the model, then advance the model
    task automatic step(input logic b, input string tag);
        logic [3:0] h;
        int         n;
        logic       exp;
        @(negedge clk);
        serial_in = b;
        #1;
        h   = {ref_hist[2:0], b};
        n   = ref_cnt + 1;
        exp = (n >= 4) && (h == 4'b1101);
        check(match_flag, exp, tag);
        @(posedge clk);
        if (ref_pos == 255) begin
            ref_pos  = 0;
            ref_cnt  = 0;
            ref_hist = 4'b0;
        end else begin
            ref_pos++;
            ref_cnt  = n;
            ref_hist = h;
        end
    endtask

    task automatic fill_zero_to(input int pos_target, input string tag);
        while (ref_pos != pos_target) step(1'b0, tag);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();

        // table walk: R1 basic, R3 overlap, R2 restart, R4 run of ones
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            serial_in = VEC[i][1];
            #1;
            check(match_flag, VEC[i][0], "R1/R2/R3/R4 table");
            @(posedge clk);
            ref_pos++;
        end

        // R9: reset state, idle recognizer even with a 1 at the input
        do_reset();
        step(1'b1, "R9 reset state");
        step(1'b1, "R9");
        step(1'b0, "R9");
        // R9: partial 110 abandoned by reset
        do_reset();
        step(1'b1, "R9 after reset");
        step(1'b1, "R9");
        step(1'b1, "R9");
        step(1'b0, "R9");
        do_reset();
        step(1'b1, "R9 no completion");

        // R5/R6: block re-aligned by reset, match ends at position 255
        fill_zero_to(252, "R5 fill");
        step(1'b1, "R6");
        step(1'b1, "R6");
        step(1'b0, "R6");
        step(1'b1, "R6 match at 255");

        // R8: fresh block, match at positions 0..3
        step(1'b1, "R8");
        step(1'b1, "R8");
        step(1'b0, "R8");
        step(1'b1, "R8 match at 3");

        // R7: partial 110 at 253..255 dropped at wrap
        fill_zero_to(253, "R5 fill");
        step(1'b1, "R7");
        step(1'b1, "R7");
        step(1'b0, "R7");
        step(1'b1, "R7 no flag at 0");
        step(1'b1, "R7");
        step(1'b0, "R7");
        step(1'b1, "R7 match at 3");

        // R7: 1,1 at 254..255 then 0,1 -> no flag at position 1
        fill_zero_to(254, "R5 fill");
        step(1'b1, "R7");
        step(1'b1, "R7");
        step(1'b0, "R7");
        step(1'b1, "R7 no flag at 1");

        // R3/R2 across a whole block with model
        fill_zero_to(0, "R5 fill");
        for (int k = 0; k < 40; k++) step(((k % 3) != 2) ? 1'b1 : ((k % 6) == 5), "R3 mixed");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule